// File: doc/BRIEF.md
# Windowed Word-Address Generator

This block forms the block-RAM word address for a load or store. It takes a 16-bit base value from an address register and can fold in a 10-bit immediate offset. The offset is combined by bitwise XOR rather than by addition, which removes the carry chain. The XOR equals addition whenever the base is aligned so that the bits the immediate touches are zero. When they are not zero, the immediate steps to a neighbouring aligned group.

The top two bits of the effective address pick a data-width window. Code 0 is 32-bit elements, 1 is 16-bit, 2 is 8-bit and 3 is 4-bit. The address is shifted right by the window code to give a 10-bit index into a 1024 x 32-bit RAM. The window code and the sub-word lane bits are passed out with the word address, so the pack and unpack logic beside the RAM can select the right part of the word.

The work is split into three registered stages, one after the other:
1. Base capture.
2. Optional XOR.
3. Translation.

A valid strobe travels with the data, and a new request can enter on every clock.

Top module: `addr_window_gen`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_word_addr`, `out_win` and `out_lane` are all zero.
- R2: Each request appears at the outputs after exactly three rising clock edges. `out_valid` repeats the `in_valid` pattern delayed by three cycles, including bubbles, and one request per cycle is accepted.
- R3: With `in_xor_en` = 1, the effective address is `in_base` XOR the immediate zero-extended to 16 bits.
- R4: With `in_xor_en` = 0, the effective address is `in_base` and `in_imm` has no effect on any output.
- R5: Window code w = effective address bits [15:14]. `out_word_addr` is effective bits [9:0] for w=0, [10:1] for w=1, [11:2] for w=2 and [12:3] for w=3. Bits above the selected slice are ignored.
- R6: `out_win` equals effective bits [15:14], which always equal `in_base[15:14]`. No immediate can change the window.
- R7: `out_lane` holds the effective bits shifted out by the window, right-aligned, with the rest zero: 000 for w=0, {00,a[0]} for w=1, {0,a[1:0]} for w=2, a[2:0] for w=3.
- R8: Suppose the low n bits of the base are zero and the immediate is below 2^n. Then the outputs equal those for base plus immediate.
- R9: Immediate bits that overlap set base bits select the XOR-neighbour group. For example, group 01 with offset 10 gives group 11, and group 11 with offset 01 gives group 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_base | input | 16 | Base value read from the address register |
| in_imm | input | 10 | Immediate offset |
| in_xor_en | input | 1 | Apply the immediate by XOR when 1 |
| out_valid | output | 1 | Translated result is valid |
| out_word_addr | output | 10 | 32-bit word index into the RAM |
| out_win | output | 2 | Window (element width) code |
| out_lane | output | 3 | Sub-word lane bits for pack/unpack |

## Verification
The bench targets the edges of every window:
- An all-ones low field, where a wrong shift would leak higher bits or lose bit 9 of the index.
- Window 0 with low bits set, which must still give zero lanes; a lane mask off by one would not.
- An immediate that sets every offset bit, which shows that an XOR reaching past bit 9 or a sign-extended immediate would corrupt the window.
- XOR overlaps on set group bits, where an adder put in place of the XOR would carry into the next group.
- A stream with gaps, so that a stage left out or duplicated shows up as a shifted valid pattern.

// File: rtl/awg_pkg.sv
package awg_pkg;

    localparam int unsigned AWG_ADDR_W = 16;
    localparam int unsigned AWG_IMM_W  = 10;
    localparam int unsigned AWG_WORD_W = 10;
    localparam int unsigned AWG_WIN_W  = 2;
    localparam int unsigned AWG_NWIN   = 1 << AWG_WIN_W;
    localparam int unsigned AWG_LANE_W = AWG_NWIN - 1;

    typedef enum logic [AWG_WIN_W-1:0] {
        WIN_WORD   = 2'd0,
        WIN_HALF   = 2'd1,
        WIN_BYTE   = 2'd2,
        WIN_NIBBLE = 2'd3
    } win_code_e;

endpackage

// File: rtl/awg_fetch_stage.sv
module awg_fetch_stage #(
    parameter int unsigned ADDR_W = awg_pkg::AWG_ADDR_W,
    parameter int unsigned IMM_W  = awg_pkg::AWG_IMM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_base,
    input  logic [IMM_W-1:0]  in_imm,
    input  logic              in_xor_en,
    output logic              q_valid,
    output logic [ADDR_W-1:0] q_base,
    output logic [IMM_W-1:0]  q_imm,
    output logic              q_xor_en
);

    // Stage 1: capture the register-file base and the opcode fields.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_valid  <= 1'b0;
            q_base   <= '0;
            q_imm    <= '0;
            q_xor_en <= 1'b0;
        end else begin
            q_valid  <= in_valid;
            q_base   <= in_base;
            q_imm    <= in_imm;
            q_xor_en <= in_xor_en;
        end
    end

endmodule

// File: rtl/awg_xor_stage.sv
module awg_xor_stage #(
    parameter int unsigned ADDR_W = awg_pkg::AWG_ADDR_W,
    parameter int unsigned IMM_W  = awg_pkg::AWG_IMM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              d_valid,
    input  logic [ADDR_W-1:0] d_base,
    input  logic [IMM_W-1:0]  d_imm,
    input  logic              d_xor_en,
    output logic              q_valid,
    output logic [ADDR_W-1:0] q_eff
);

    localparam int unsigned PAD_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] imm_ext;
    logic [ADDR_W-1:0] eff_next;

    // The immediate is zero-extended, so the window bits are never touched.
    assign imm_ext = {{PAD_W{1'b0}}, d_imm};

    always_comb begin
        eff_next = d_base;
        if (d_xor_en) begin
            eff_next = d_base ^ imm_ext;
        end
    end

    // Stage 2: register the effective address.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_eff   <= '0;
        end else begin
            q_valid <= d_valid;
            q_eff   <= eff_next;
        end
    end

endmodule

// File: rtl/awg_xlate_stage.sv
module awg_xlate_stage #(
    parameter int unsigned ADDR_W = awg_pkg::AWG_ADDR_W,
    parameter int unsigned WORD_W = awg_pkg::AWG_WORD_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            d_valid,
    input  logic [ADDR_W-1:0]               d_eff,
    output logic                            q_valid,
    output logic [WORD_W-1:0]               q_word_addr,
    output logic [awg_pkg::AWG_WIN_W-1:0]   q_win,
    output logic [awg_pkg::AWG_LANE_W-1:0]  q_lane
);

    import awg_pkg::*;

    localparam int unsigned NWIN   = AWG_NWIN;
    localparam int unsigned LANE_W = AWG_LANE_W;
    localparam int unsigned LOW_W  = WORD_W + LANE_W;
    localparam int unsigned MID_HI = ADDR_W - AWG_WIN_W - 1;

    logic [AWG_WIN_W-1:0] win_bits;
    win_code_e            win_e;
    logic [WORD_W-1:0]    cand_addr [NWIN];
    logic [LANE_W-1:0]    cand_lane [NWIN];
    logic [WORD_W-1:0]    addr_next;
    logic [LANE_W-1:0]    lane_next;
    logic                 unused_mid;

    assign win_bits = d_eff[ADDR_W-1 -: AWG_WIN_W];
    assign win_e    = win_code_e'(win_bits);

    // Bits between the widest slice and the window code are never addressed.
    assign unused_mid = ^d_eff[MID_HI:LOW_W];

    // One candidate slice and lane mask per window code.
    for (genvar g = 0; g < NWIN; g++) begin : g_win
        localparam logic [LANE_W-1:0] LANE_MASK = LANE_W'((1 << g) - 1);
        assign cand_addr[g] = d_eff[g +: WORD_W];
        assign cand_lane[g] = d_eff[LANE_W-1:0] & LANE_MASK;
    end

    always_comb begin
        addr_next = cand_addr[0];
        lane_next = cand_lane[0];
        unique case (win_e)
            WIN_WORD: begin
                addr_next = cand_addr[0];
                lane_next = cand_lane[0];
            end
            WIN_HALF: begin
                addr_next = cand_addr[1];
                lane_next = cand_lane[1];
            end
            WIN_BYTE: begin
                addr_next = cand_addr[2];
                lane_next = cand_lane[2];
            end
            WIN_NIBBLE: begin
                addr_next = cand_addr[3];
                lane_next = cand_lane[3];
            end
        endcase
    end

    // Stage 3: register the translated result.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_valid     <= 1'b0;
            q_word_addr <= '0;
            q_win       <= '0;
            q_lane      <= '0;
        end else begin
            q_valid     <= d_valid;
            q_word_addr <= addr_next;
            q_win       <= win_bits;
            q_lane      <= lane_next;
        end
    end

endmodule

// File: rtl/addr_window_gen.sv
module addr_window_gen #(
    parameter int unsigned ADDR_W = awg_pkg::AWG_ADDR_W,
    parameter int unsigned IMM_W  = awg_pkg::AWG_IMM_W,
    parameter int unsigned WORD_W = awg_pkg::AWG_WORD_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    input  logic [ADDR_W-1:0]               in_base,
    input  logic [IMM_W-1:0]                in_imm,
    input  logic                            in_xor_en,
    output logic                            out_valid,
    output logic [WORD_W-1:0]               out_word_addr,
    output logic [awg_pkg::AWG_WIN_W-1:0]   out_win,
    output logic [awg_pkg::AWG_LANE_W-1:0]  out_lane
);

    logic              s1_valid;
    logic [ADDR_W-1:0] s1_base;
    logic [IMM_W-1:0]  s1_imm;
    logic              s1_xor_en;
    logic              s2_valid;
    logic [ADDR_W-1:0] s2_eff;

    awg_fetch_stage #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_base   (in_base),
        .in_imm    (in_imm),
        .in_xor_en (in_xor_en),
        .q_valid   (s1_valid),
        .q_base    (s1_base),
        .q_imm     (s1_imm),
        .q_xor_en  (s1_xor_en)
    );

    awg_xor_stage #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_xor (
        .clk      (clk),
        .rst_n    (rst_n),
        .d_valid  (s1_valid),
        .d_base   (s1_base),
        .d_imm    (s1_imm),
        .d_xor_en (s1_xor_en),
        .q_valid  (s2_valid),
        .q_eff    (s2_eff)
    );

    awg_xlate_stage #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_xlate (
        .clk         (clk),
        .rst_n       (rst_n),
        .d_valid     (s2_valid),
        .d_eff       (s2_eff),
        .q_valid     (out_valid),
        .q_word_addr (out_word_addr),
        .q_win       (out_win),
        .q_lane      (out_lane)
    );

endmodule

// File: rtl/awg_checker.sv
module awg_checker #(
    parameter int unsigned ADDR_W = awg_pkg::AWG_ADDR_W,
    parameter int unsigned IMM_W  = awg_pkg::AWG_IMM_W,
    parameter int unsigned WORD_W = awg_pkg::AWG_WORD_W
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            in_valid,
    input logic [ADDR_W-1:0]               in_base,
    input logic [IMM_W-1:0]                in_imm,
    input logic                            in_xor_en,
    input logic                            out_valid,
    input logic [WORD_W-1:0]               out_word_addr,
    input logic [awg_pkg::AWG_WIN_W-1:0]   out_win,
    input logic [awg_pkg::AWG_LANE_W-1:0]  out_lane
);

    localparam int unsigned PAD_W = ADDR_W - IMM_W;

    logic [1:0]        since_rst;
    logic [ADDR_W-1:0] imm_wide;

    assign imm_wide = {{PAD_W{1'b0}}, in_imm};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R6
    window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_win == $past(in_base[ADDR_W-1 -: 2], 3)));

    // R7
    lane_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_win == 2'd0) |-> (out_lane == 3'b000));

    // R7
    lane_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_win == 2'd1) |-> (out_lane[2:1] == 2'b00));

    // R7
    lane_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_win == 2'd2) |-> (out_lane[2] == 1'b0));

    // R4
    plain_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst == 2'd3) && $past(!in_xor_en, 3)
            && $past(in_base[ADDR_W-1 -: 2] == 2'b00, 3))
        |-> (out_word_addr == $past(in_base[WORD_W-1:0], 3)));

    // R3
    xor_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst == 2'd3) && $past(in_xor_en, 3)
            && $past(in_base[ADDR_W-1 -: 2] == 2'b00, 3))
        |-> (out_word_addr == $past(in_base[WORD_W-1:0] ^ imm_wide[WORD_W-1:0], 3)));

endmodule

bind addr_window_gen awg_checker #(
    .ADDR_W (ADDR_W),
    .IMM_W  (IMM_W),
    .WORD_W (WORD_W)
) u_awg_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_base       (in_base),
    .in_imm        (in_imm),
    .in_xor_en     (in_xor_en),
    .out_valid     (out_valid),
    .out_word_addr (out_word_addr),
    .out_win       (out_win),
    .out_lane      (out_lane)
);

// File: tb/test_addr_window_gen.sv
module test_addr_window_gen;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 14;

    // Row: base[41:26] imm[25:16] xor_en[15] addr[14:5] win[4:3] lane[2:0]
    localparam logic [41:0] VEC [NVEC] = '{
        {16'h0000, 10'h000, 1'b0, 10'h000, 2'd0, 3'b000},
        {16'h0123, 10'h3FF, 1'b0, 10'h123, 2'd0, 3'b000},
        {16'h0100, 10'h023, 1'b1, 10'h123, 2'd0, 3'b000},
        {16'h4246, 10'h000, 1'b0, 10'h123, 2'd1, 3'b000},
        {16'h4247, 10'h000, 1'b0, 10'h123, 2'd1, 3'b001},
        {16'h8000, 10'h3FF, 1'b1, 10'h0FF, 2'd2, 3'b011},
        {16'hC008, 10'h000, 1'b0, 10'h001, 2'd3, 3'b000},
        {16'hDFFF, 10'h000, 1'b0, 10'h3FF, 2'd3, 3'b111},
        {16'h3FFF, 10'h000, 1'b0, 10'h3FF, 2'd0, 3'b000},
        {16'h0010, 10'h020, 1'b1, 10'h030, 2'd0, 3'b000},
        {16'h0030, 10'h010, 1'b1, 10'h020, 2'd0, 3'b000},
        {16'h4000, 10'h3FF, 1'b1, 10'h1FF, 2'd1, 3'b001},
        {16'h0140, 10'h00F, 1'b1, 10'h14F, 2'd0, 3'b000},
        {16'h8ABC, 10'h155, 1'b0, 10'h2AF, 2'd2, 3'b000}
    };

    localparam string ROW_REQ [NVEC] = '{
        "R5", "R4", "R3", "R5", "R7", "R3 R7", "R5", "R7",
        "R5 R7", "R9", "R9", "R6", "R8", "R4"
    };

    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic [15:0] in_base;
    logic [9:0]  in_imm;
    logic        in_xor_en;
    logic        out_valid;
    logic [9:0]  out_word_addr;
    logic [1:0]  out_win;
    logic [2:0]  out_lane;

    int checks;
    int errors;
    bit done;

    addr_window_gen i_addr_window_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_base       (in_base),
        .in_imm        (in_imm),
        .in_xor_en     (in_xor_en),
        .out_valid     (out_valid),
        .out_word_addr (out_word_addr),
        .out_win       (out_win),
        .out_lane      (out_lane)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [15:0] b,
                         input logic [9:0] im, input logic x);
        in_valid  = v;
        in_base   = b;
        in_imm    = im;
        in_xor_en = x;
    endtask

    // Issue one request and return the outputs three edges later.
    task automatic run_one(input logic [15:0] b, input logic [9:0] im,
                           input logic x, output logic [9:0] a,
                           output logic [1:0] w, output logic [2:0] l);
        @(negedge clk);
        drive(1'b1, b, im, x);
        @(negedge clk);
        drive(1'b0, 16'h0, 10'h0, 1'b0);
        @(negedge clk);
        @(negedge clk);
        a = out_word_addr;
        w = out_win;
        l = out_lane;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [9:0] a;
        logic [1:0] w;
        logic [2:0] l;
        logic [15:0] sum;
        logic [9:0] imm_k;

        checks = 0;
        errors = 0;
        done   = 1'b0;
        rst_n  = 1'b0;
        drive(1'b1, 16'hFFFF, 10'h3FF, 1'b1);

        // R1: outputs held at zero during reset
        repeat (3) @(negedge clk);
        check("R1", "valid in reset", 32'(out_valid), 32'd0);
        check("R1", "addr in reset", 32'(out_word_addr), 32'd0);
        check("R1", "win in reset", 32'(out_win), 32'd0);
        check("R1", "lane in reset", 32'(out_lane), 32'd0);

        drive(1'b0, 16'h0, 10'h0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table streamed back to back, one row per cycle (R2 throughput)
        for (int i = 0; i < NVEC + 3; i++) begin
            @(negedge clk);
            if (i >= 3) begin
                check(ROW_REQ[i-3], $sformatf("row %0d addr", i - 3),
                      32'(out_word_addr), 32'(VEC[i-3][14:5]));
                check(ROW_REQ[i-3], $sformatf("row %0d win", i - 3),
                      32'(out_win), 32'(VEC[i-3][4:3]));
                check(ROW_REQ[i-3], $sformatf("row %0d lane", i - 3),
                      32'(out_lane), 32'(VEC[i-3][2:0]));
                check("R2", $sformatf("row %0d valid", i - 3),
                      32'(out_valid), 32'd1);
            end
            if (i < NVEC) begin
                drive(1'b1, VEC[i][41:26], VEC[i][25:16], VEC[i][15]);
            end else begin
                drive(1'b0, 16'h0, 10'h0, 1'b0);
            end
        end

        // R2: bubble pattern survives the pipeline with three cycles of delay
        begin
            logic [7:0] pat;
            pat = 8'b1011_0010;
            for (int i = 0; i < 11; i++) begin
                @(negedge clk);
                if (i >= 3) begin
                    check("R2", $sformatf("bubble slot %0d", i - 3),
                          32'(out_valid), 32'(pat[i-3]));
                end
                if (i < 8) begin
                    drive(pat[i], 16'h0040, 10'h001, 1'b1);
                end else begin
                    drive(1'b0, 16'h0, 10'h0, 1'b0);
                end
            end
        end

        // R4: immediate ignored when XOR is off, against a zero immediate
        run_one(16'hC5A8, 10'h2D7, 1'b0, a, w, l);
        check("R4", "imm ignored addr", 32'(a), 32'h0B5);
        check("R4", "imm ignored lane", 32'(l), 32'd0);

        // R6: every immediate bit set leaves the nibble window in place
        run_one(16'hC000, 10'h3FF, 1'b1, a, w, l);
        check("R6", "window kept", 32'(w), 32'd3);
        check("R7", "nibble lane", 32'(l), 32'b111);

        // R8: aligned base, XOR must match addition
        for (int k = 0; k < 12; k++) begin
            imm_k = 10'(k * 41);
            sum = 16'h0200 + {6'd0, imm_k};
            run_one(16'h0200, imm_k, 1'b1, a, w, l);
            check("R8", $sformatf("word window k=%0d", k), 32'(a), 32'(sum[9:0]));
        end
        for (int k = 0; k < 6; k++) begin
            imm_k = 10'(k * 97);
            sum = 16'h4400 + {6'd0, imm_k};
            run_one(16'h4400, imm_k, 1'b1, a, w, l);
            check("R8", $sformatf("half window k=%0d addr", k), 32'(a), 32'(sum[10:1]));
            check("R8", $sformatf("half window k=%0d lane", k), 32'(l), {31'd0, sum[0]});
        end

        // R9: 10 XOR 11 steps to group 01 (differs from addition)
        run_one(16'h0020, 10'h030, 1'b1, a, w, l);
        check("R9", "group 10^11", 32'(a), 32'h010);

        // R1: reset asserted mid-stream clears the pipeline
        @(negedge clk);
        drive(1'b1, 16'hDFFF, 10'h0, 1'b0);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", "mid reset valid", 32'(out_valid), 32'd0);
        check("R1", "mid reset addr", 32'(out_word_addr), 32'd0);
        check("R1", "mid reset lane", 32'(out_lane), 32'd0);
        drive(1'b0, 16'h0, 10'h0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "after reset valid", 32'(out_valid), 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule